// File: doc/BRIEF.md
# Multi-Cycle Accumulator Processor

This block is a small stored-program machine built around one accumulator. It holds a program counter, an instruction register and the accumulator. A single memory holds both instructions and data and sits outside the block. One ALU does every piece of arithmetic the machine needs: it advances the program counter, moves a jump target into the program counter, and computes the accumulator results. A control state machine steers the ALU through zero-A, carry-in, B-invert and logic/adder select lines. It also drives a B-operand multiplexer, a new-value multiplexer, the register load enables and the memory write enable.

Each instruction takes three cycles: fetch, increment and execute. An instruction word has a 3-bit opcode in bits [7:5] and a 5-bit address in bits [4:0]. The memory port is the block's only interface. Memory writes land on the clock edge, and read data follows the address in the same cycle. The address comes either from the program counter or from the address field of the instruction register.

Top module: `acc_cpu`

## Requirements
- R1: A synchronous active-high reset clears the program counter, instruction register and accumulator and enters the fetch state, so the first cycle after reset presents address 0 with the write enable low.
- R2: Every instruction takes exactly three cycles (fetch, increment, execute). The fetch cycle presents the program counter on the address port, and the program counter then advances by one, wrapping modulo 32.
- R3: LOAD (opcode 000) copies the memory word at the address field into the accumulator.
- R4: STORE (opcode 001) raises the write enable for exactly one cycle, in its execute cycle, with the address field on the address port and the accumulator on the write-data port. The write enable is low in every other cycle.
- R5: ADD (opcode 010) replaces the accumulator with the accumulator plus the addressed memory word, modulo 256.
- R6: AND (opcode 011) replaces the accumulator with the bitwise AND of the accumulator and the addressed word.
- R7: OR (opcode 100) replaces the accumulator with the bitwise OR of the accumulator and the addressed word.
- R8: JMP (opcode 101) loads the program counter with the address field, so the next fetch is from that address and the skipped words are not executed.
- R9: Opcodes 110 and 111 change neither the accumulator nor the program-counter sequence.
- R10: Instructions and data share the memory, so a word written by STORE and later fetched is executed as an instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 5 | Memory address, from the program counter or the instruction address field |
| mem_wdata | output | 8 | Write data, the accumulator |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 8 | Memory read data for the current address |

## Verification
A STORE can write a word in the same cycle that the address mux points at that word. If the word is an instruction the program has not yet reached, a later fetch of it must return the new value. The test program provokes this by storing a STORE instruction over a later no-op. It then judges the result by the second store that the rewritten word performs. The program also combines a JMP with skipped STOREs, so the fetch-address sequence and the untouched skipped target show that a branch and the counter increment never both take effect.

// File: rtl/acc_cpu.sv
module acc_cpu #(
  parameter int DW = 8,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  input  logic [DW-1:0] mem_rdata
);
  localparam int OPW = DW - AW;
  localparam logic [OPW-1:0] OP_LOAD = 3'd0, OP_STORE = 3'd1, OP_ADD = 3'd2,
                             OP_AND = 3'd3, OP_OR = 3'd4, OP_JMP = 3'd5;

  typedef enum logic [1:0] {S_FETCH, S_INCPC, S_EXEC} state_t;
  typedef enum logic [1:0] {B_MEM, B_PC, B_IR} bsel_t;

  state_t          state;
  logic [AW-1:0]   pc;
  logic [DW-1:0]   ir, acc;
  logic [OPW-1:0]  op;
  logic [AW-1:0]   field;

  logic  ld_pc, ld_ir, ld_acc, addr_ir, new_mem;
  logic  zero_a, cin, binv, use_logic;
  bsel_t bsel;

  logic [DW-1:0] a_op, b_op, b_adj, alu_y, new_val;

  assign op    = ir[DW-1:AW];
  assign field = ir[AW-1:0];

  always_comb begin
    ld_pc = 1'b0; ld_ir = 1'b0; ld_acc = 1'b0; addr_ir = 1'b0; new_mem = 1'b0;
    zero_a = 1'b0; cin = 1'b0; binv = 1'b0; use_logic = 1'b0; bsel = B_MEM;
    mem_we = 1'b0;
    case (state)
      S_FETCH: begin ld_ir = 1'b1; new_mem = 1'b1; end
      S_INCPC: begin ld_pc = 1'b1; zero_a = 1'b1; cin = 1'b1; bsel = B_PC; end
      S_EXEC: begin
        addr_ir = 1'b1;
        case (op)
          OP_LOAD:  begin ld_acc = 1'b1; zero_a = 1'b1; end
          OP_STORE: mem_we = 1'b1;
          OP_ADD:   ld_acc = 1'b1;
          OP_AND:   begin ld_acc = 1'b1; use_logic = 1'b1; end
          OP_OR:    begin ld_acc = 1'b1; use_logic = 1'b1; binv = 1'b1; end
          OP_JMP:   begin ld_pc = 1'b1; zero_a = 1'b1; bsel = B_IR; end
          default:  ;
        endcase
      end
      default: ;
    endcase
  end

  always_comb begin
    case (bsel)
      B_PC:    b_op = {{OPW{1'b0}}, pc};
      B_IR:    b_op = {{OPW{1'b0}}, field};
      default: b_op = mem_rdata;
    endcase
  end

  assign a_op    = zero_a ? '0 : acc;
  assign b_adj   = use_logic ? b_op : (b_op ^ {DW{binv}});
  assign alu_y   = use_logic ? (binv ? (a_op | b_adj) : (a_op & b_adj))
                             : (a_op + b_adj + {{(DW-1){1'b0}}, cin});
  assign new_val = new_mem ? mem_rdata : alu_y;

  assign mem_addr  = addr_ir ? field : pc;
  assign mem_wdata = acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_FETCH;
      pc    <= '0;
      ir    <= '0;
      acc   <= '0;
    end else begin
      case (state)
        S_FETCH: state <= S_INCPC;
        S_INCPC: state <= S_EXEC;
        default: state <= S_FETCH;
      endcase
      if (ld_pc)  pc  <= new_val[AW-1:0];
      if (ld_ir)  ir  <= new_val;
      if (ld_acc) acc <= new_val;
    end
  end

  a_r4_we_one_cycle: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);
  a_r2_fetch_order: assert property (@(posedge clk) disable iff (rst)
    state == S_FETCH |=> state == S_INCPC);
  a_r2_pc_step: assert property (@(posedge clk) disable iff (rst)
    state == S_INCPC |=> pc == $past(pc) + 1'b1);
  a_r8_jump_target: assert property (@(posedge clk) disable iff (rst)
    (state == S_EXEC && op == OP_JMP) |=> pc == $past(field));
  a_r5_add_sum: assert property (@(posedge clk) disable iff (rst)
    (state == S_EXEC && op == OP_ADD) |=> acc == $past(acc) + $past(mem_rdata));
  a_r9_nop_quiet: assert property (@(posedge clk) disable iff (rst)
    (state == S_EXEC && op > OP_JMP) |=> ($stable(acc) && $stable(pc)));
endmodule

// File: tb/tb_acc_cpu.sv
module tb_acc_cpu;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic       mem_we;
  logic [7:0] mem [32];
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  acc_cpu dut (.clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
               .mem_we(mem_we), .mem_rdata(mem_rdata));

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

  localparam int NF = 18;
  localparam logic [4:0] FETCH_PC [NF] = '{5'd0, 5'd1, 5'd2, 5'd3, 5'd4, 5'd5, 5'd6,
    5'd7, 5'd8, 5'd9, 5'd12, 5'd13, 5'd14, 5'd15, 5'd16, 5'd17, 5'd17, 5'd17};
  localparam int NS = 7;
  localparam logic [12:0] STORES [NS] = '{{5'd24, 8'h3C}, {5'd25, 8'h41},
    {5'd26, 8'h01}, {5'd27, 8'hF1}, {5'd14, 8'h3D}, {5'd29, 8'h3D}, {5'd30, 8'h3C}};
  localparam string SREQ [NS] = '{"R3", "R5", "R6", "R7", "R10", "R10", "R5"};

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int si = 0;
    int we_cycles = 0;
    for (int i = 0; i < 32; i++) mem[i] = 8'h00;
    mem[0] = 8'h14; mem[1] = 8'h38; mem[2] = 8'h55; mem[3] = 8'h39;
    mem[4] = 8'h76; mem[5] = 8'h3A; mem[6] = 8'h97; mem[7] = 8'hC0;
    mem[8] = 8'h3B; mem[9] = 8'hAC; mem[10] = 8'h3C; mem[11] = 8'hE0;
    mem[12] = 8'h13; mem[13] = 8'h2E; mem[14] = 8'hE0; mem[15] = 8'h52;
    mem[16] = 8'h3E; mem[17] = 8'hB1;
    mem[18] = 8'hFF; mem[19] = 8'h3D; mem[20] = 8'h3C; mem[21] = 8'h05;
    mem[22] = 8'h0F; mem[23] = 8'hF0;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 reset addr", {3'b0, mem_addr}, 8'h00);
    chk("R1 reset we", {7'b0, mem_we}, 8'h00);

    for (int n = 0; n < 3 * NF; n++) begin
      if (n % 3 == 0) chk("R2/R8 fetch pc", {3'b0, mem_addr}, {3'b0, FETCH_PC[n / 3]});
      if (mem_we) begin
        we_cycles++;
        if (si < NS) begin
          chk({SREQ[si], " R4 store addr"}, {3'b0, mem_addr}, {3'b0, STORES[si][12:8]});
          chk({SREQ[si], " R4 store data"}, mem_wdata, STORES[si][7:0]);
        end
        si++;
      end
      @(negedge clk);
    end
    chk("R4 write cycles", we_cycles[7:0], 8'd7);
    chk("R8 skipped store target", mem[28], 8'h00);
    chk("R9 opcode 111 skipped target", mem[31], 8'h00);
    chk("R10 rewritten word", mem[14], 8'h3D);
    chk("R5 wrapped sum", mem[30], 8'h3C);

    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 mid-run reset addr", {3'b0, mem_addr}, 8'h00);
    chk("R1 mid-run reset we", {7'b0, mem_we}, 8'h00);
    repeat (3) @(negedge clk);
    chk("R2 second fetch", {3'b0, mem_addr}, 8'h01);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule